// File: doc/BRIEF.md
# Calendar Real-Time Clock with Alarm

This peripheral keeps the wall-clock date and time for a chip. A slow reference arrives as a one-cycle strobe, `ref_pulse`, nominally at 32.768 kHz. A programmable divider turns these strobes into a once-per-second tick. Each tick advances a packed time-of-day word and a packed date word. Month lengths and Gregorian leap years are handled in hardware, so software never has to correct the date.

One alarm holds a full date and time. It fires on the clock edge at which the running calendar becomes equal to it. A six-bit status word keeps three sticky event flags next to three interrupt enables. The flags clear only when a 1 is written to them. Two interrupt lines leave the block: one for the alarm and one for the seconds tick.

Software reaches every register over a single-cycle 32-bit bus with byte addresses. Reads are combinational. Writes take effect on the clock edge that samples them.

Top module: `cal_rtc`

## Requirements
- R1: After reset, every register reads as zero except the date, which reads as 2000-01-01 (0x000FA021). Both interrupt lines are low.
- R2: The register at offset 0x0C holds a divider D in bits [15:0] and a trim field in bits [31:16]. The whole word reads back as written. A seconds tick occurs on every (D+1)-th `ref_pulse`, and the trim field has no effect on timing.
- R3: The time register (offset 0x10) packs hour in bits [16:12], minute in bits [11:6] and second in bits [5:0]. On a tick, the second wraps to 0 after 59 and carries into the minute. The minute wraps to 0 after 59 and carries into the hour. The hour wraps to 0 after 23 and carries into the day.
- R4: The date register (offset 0x14) packs the year in bits [20:9], the month in bits [8:5] (starting at 1) and the day in bits [4:0] (starting at 1). On a day carry, the day returns to 1 after the last day of its month. February has 29 days in Gregorian leap years (divisible by 4 and not by 100, or divisible by 400). The month returns to 1 after 12 and increments the year.
- R5: A write to the time or date register is visible on the next read and produces no tick in that cycle. It restarts the divider, so the next tick needs D+1 further reference strobes.
- R6: The alarm time (offset 0x18) and alarm date (offset 0x1C) use the same layouts as R3 and R4 and read back as written. On the edge where the calendar takes a value whose date and time both equal them, status bits 0 and 4 are set.
- R7: Every tick sets status bit 1, whatever the enable bits hold.
- R8: In the status register (offset 0x08), bits 2, 3 and 5 are enables that take the written value. Flag bits 0, 1 and 4 are cleared by writing 1 to them, and a flag written with 0 keeps its value.
- R9: `irq_alarm` is high while (bit 0 and bit 2) or (bit 4 and bit 5) are set. `irq_tick` is high while bit 1 and bit 3 are set.
- R10: Offsets other than 0x08, 0x0C, 0x10, 0x14, 0x18 and 0x1C read as zero, and writes to them are ignored. This includes unaligned offsets. Reserved bits read as zero: status [31:6], time [31:17], date [31:21] and the alarm registers likewise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ref_pulse | input | 1 | One-cycle strobe per reference clock period |
| bus_en | input | 1 | Bus access in this cycle |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, zero when no read is in progress |
| irq_alarm | output | 1 | Alarm interrupt line |
| irq_tick | output | 1 | Seconds interrupt line |

## Verification
The calendar is started from a table of twelve date and time values. Each entry sits just before a different boundary: a plain second step, a minute carry, an hour carry, a day carry, and month ends of 30 and 31 days. The table also covers a year end and February in an ordinary year, in a year divisible by 4, in 2000 and in 2100. Together these separate a correct leap rule from one that ignores the century or the 400-year exception. A divider value of 3, combined with a mid-count write, shows whether the strobe count restarts or keeps running. The status sequence sets and clears each flag with its enable both set and clear, which separates the stickiness of the flags from the gating of the interrupt lines.

// File: rtl/rtc_pkg.sv
`timescale 1ns/1ps
package rtc_pkg;

    // Register byte offsets (software decodes these)
    localparam int unsigned OFS_STATUS = 8'h08;
    localparam int unsigned OFS_DIVTRM = 8'h0C;
    localparam int unsigned OFS_TOD    = 8'h10;
    localparam int unsigned OFS_DATE   = 8'h14;
    localparam int unsigned OFS_ATOD   = 8'h18;
    localparam int unsigned OFS_ADATE  = 8'h1C;

    // Status bit positions
    localparam int unsigned ST_W       = 6;
    localparam int unsigned ST_ALM_F   = 0;
    localparam int unsigned ST_TICK_F  = 1;
    localparam int unsigned ST_ALM_EN  = 2;
    localparam int unsigned ST_TICK_EN = 3;
    localparam int unsigned ST_CAL_F   = 4;
    localparam int unsigned ST_CAL_EN  = 5;
    localparam logic [ST_W-1:0] FLAG_MASK = 6'b01_0011;
    localparam logic [ST_W-1:0] EN_MASK   = 6'b10_1100;

    // Field widths and limits
    localparam int unsigned YEAR_W = 12;
    localparam int unsigned MON_W  = 4;
    localparam int unsigned DAY_W  = 5;
    localparam int unsigned HOUR_W = 5;
    localparam int unsigned MIN_W  = 6;
    localparam int unsigned SEC_W  = 6;
    localparam int unsigned TOD_W  = HOUR_W + MIN_W + SEC_W;
    localparam int unsigned DATE_W = YEAR_W + MON_W + DAY_W;

    localparam logic [SEC_W-1:0]  SEC_LAST  = 6'd59;
    localparam logic [MIN_W-1:0]  MIN_LAST  = 6'd59;
    localparam logic [HOUR_W-1:0] HOUR_LAST = 5'd23;
    localparam logic [MON_W-1:0]  MON_LAST  = 4'd12;

    // Packed order equals the register bit layout
    typedef struct packed {
        logic [HOUR_W-1:0] hour;
        logic [MIN_W-1:0]  minute;
        logic [SEC_W-1:0]  second;
    } tod_t;

    typedef struct packed {
        logic [YEAR_W-1:0] year;
        logic [MON_W-1:0]  month;
        logic [DAY_W-1:0]  day;
    } date_t;

    typedef struct packed {
        tod_t  tod;
        date_t date;
    } cal_t;

    typedef struct packed {
        logic [31:0]     divtrim;
        tod_t            alm_tod;
        date_t           alm_date;
        logic [ST_W-1:0] status;
    } regs_t;

    function automatic logic leap_year(input logic [YEAR_W-1:0] y);
        logic by4, by100, by400;
        by4   = (y % 12'd4)   == '0;
        by100 = (y % 12'd100) == '0;
        by400 = (y % 12'd400) == '0;
        return (by4 && !by100) || by400;
    endfunction

    function automatic logic [DAY_W-1:0] month_len(input logic [YEAR_W-1:0] y,
                                                   input logic [MON_W-1:0]  m);
        logic [DAY_W-1:0] len;
        case (m)
            4'd2:                    len = leap_year(y) ? 5'd29 : 5'd28;
            4'd4, 4'd6, 4'd9, 4'd11: len = 5'd30;
            default:                 len = 5'd31;
        endcase
        return len;
    endfunction

endpackage

// File: rtl/rtc_divider.sv
`timescale 1ns/1ps
module rtc_divider #(
    parameter int unsigned CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ref_pulse,
    input  logic             restart,
    input  logic [CNT_W-1:0] div_val,
    output logic             tick
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        tick = 1'b0;
        if (restart) begin
            st_d.cnt = '0;
        end else if (ref_pulse) begin
            if (st_q.cnt >= div_val) begin
                st_d.cnt = '0;
                tick     = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end
endmodule

// File: rtl/rtc_calendar.sv
`timescale 1ns/1ps
module rtc_calendar
    import rtc_pkg::*;
#(
    parameter int unsigned RESET_YEAR = 2000
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  tick,
    input  logic  wr_tod,
    input  logic  wr_date,
    input  tod_t  tod_wdata,
    input  date_t date_wdata,
    output cal_t  cal_now,
    output cal_t  cal_next,
    output logic  cal_upd
);
    localparam date_t RST_DATE = '{year: YEAR_W'(RESET_YEAR), month: 4'd1, day: 5'd1};

    cal_t cal_d, cal_q;
    logic sec_c, min_c, hr_c, day_c, mon_c;

    always_comb begin
        sec_c = cal_q.tod.second >= SEC_LAST;
        min_c = sec_c && (cal_q.tod.minute >= MIN_LAST);
        hr_c  = min_c && (cal_q.tod.hour >= HOUR_LAST);
        day_c = hr_c  && (cal_q.date.day >= month_len(cal_q.date.year, cal_q.date.month));
        mon_c = day_c && (cal_q.date.month >= MON_LAST);

        cal_d = cal_q;
        if (wr_tod || wr_date) begin
            if (wr_tod)  cal_d.tod  = tod_wdata;
            if (wr_date) cal_d.date = date_wdata;
        end else if (tick) begin
            cal_d.tod.second = sec_c ? '0 : cal_q.tod.second + 1'b1;
            if (sec_c) cal_d.tod.minute = min_c ? '0 : cal_q.tod.minute + 1'b1;
            if (min_c) cal_d.tod.hour   = hr_c  ? '0 : cal_q.tod.hour + 1'b1;
            if (hr_c)  cal_d.date.day   = day_c ? 5'd1 : cal_q.date.day + 1'b1;
            if (day_c) cal_d.date.month = mon_c ? 4'd1 : cal_q.date.month + 1'b1;
            if (mon_c) cal_d.date.year  = cal_q.date.year + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cal_q <= '{tod: '0, date: RST_DATE};
        else        cal_q <= cal_d;
    end

    assign cal_now  = cal_q;
    assign cal_next = cal_d;
    assign cal_upd  = tick || wr_tod || wr_date;
endmodule

// File: rtl/rtc_alarm_match.sv
`timescale 1ns/1ps
module rtc_alarm_match
    import rtc_pkg::*;
(
    input  logic  cal_upd,
    input  cal_t  cal_next,
    input  tod_t  alm_tod,
    input  date_t alm_date,
    output logic  hit
);
    logic tod_eq, date_eq;

    always_comb begin
        tod_eq  = cal_next.tod  == alm_tod;
        date_eq = cal_next.date == alm_date;
        hit     = cal_upd && tod_eq && date_eq;
    end
endmodule

// File: rtl/cal_rtc.sv
`timescale 1ns/1ps
module cal_rtc
    import rtc_pkg::*;
#(
    parameter int unsigned ADDR_W     = 8,
    parameter int unsigned DIV_W      = 16,
    parameter int unsigned RESET_YEAR = 2000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ref_pulse,
    input  logic              bus_en,
    input  logic              bus_we,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata,
    output logic              irq_alarm,
    output logic              irq_tick
);
    regs_t regs_d, regs_q;

    logic hit_status, hit_div, hit_tod, hit_date, hit_atod, hit_adate, addr_hit;
    logic wr_acc, rd_acc, wr_status, wr_tod, wr_date, wr_cal;
    logic div_tick, cal_upd, alarm_hit;
    cal_t cal_now, cal_next;
    logic [ST_W-1:0] stat_word;

    // Address decode
    always_comb begin
        hit_status = bus_addr == ADDR_W'(OFS_STATUS);
        hit_div    = bus_addr == ADDR_W'(OFS_DIVTRM);
        hit_tod    = bus_addr == ADDR_W'(OFS_TOD);
        hit_date   = bus_addr == ADDR_W'(OFS_DATE);
        hit_atod   = bus_addr == ADDR_W'(OFS_ATOD);
        hit_adate  = bus_addr == ADDR_W'(OFS_ADATE);
        addr_hit   = hit_status | hit_div | hit_tod | hit_date | hit_atod | hit_adate;
        wr_acc     = bus_en && bus_we;
        rd_acc     = bus_en && !bus_we;
        wr_status  = wr_acc && hit_status;
        wr_tod     = wr_acc && hit_tod;
        wr_date    = wr_acc && hit_date;
        wr_cal     = wr_tod || wr_date;
    end

    rtc_divider #(.CNT_W(DIV_W)) u_div (
        .clk       (clk),
        .rst_n     (rst_n),
        .ref_pulse (ref_pulse),
        .restart   (wr_cal),
        .div_val   (regs_q.divtrim[DIV_W-1:0]),
        .tick      (div_tick)
    );

    rtc_calendar #(.RESET_YEAR(RESET_YEAR)) u_cal (
        .clk        (clk),
        .rst_n      (rst_n),
        .tick       (div_tick),
        .wr_tod     (wr_tod),
        .wr_date    (wr_date),
        .tod_wdata  (tod_t'(bus_wdata[TOD_W-1:0])),
        .date_wdata (date_t'(bus_wdata[DATE_W-1:0])),
        .cal_now    (cal_now),
        .cal_next   (cal_next),
        .cal_upd    (cal_upd)
    );

    rtc_alarm_match u_alm (
        .cal_upd  (cal_upd),
        .cal_next (cal_next),
        .alm_tod  (regs_q.alm_tod),
        .alm_date (regs_q.alm_date),
        .hit      (alarm_hit)
    );

    // Next-state of the register file
    always_comb begin
        regs_d = regs_q;
        if (wr_acc && hit_div)   regs_d.divtrim  = bus_wdata;
        if (wr_acc && hit_atod)  regs_d.alm_tod  = tod_t'(bus_wdata[TOD_W-1:0]);
        if (wr_acc && hit_adate) regs_d.alm_date = date_t'(bus_wdata[DATE_W-1:0]);
        if (wr_status) begin
            regs_d.status = (regs_q.status & FLAG_MASK & ~bus_wdata[ST_W-1:0])
                          | (bus_wdata[ST_W-1:0] & EN_MASK);
        end
        if (alarm_hit) begin
            regs_d.status[ST_ALM_F] = 1'b1;
            regs_d.status[ST_CAL_F] = 1'b1;
        end
        if (div_tick) regs_d.status[ST_TICK_F] = 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) regs_q <= '0;
        else        regs_q <= regs_d;
    end

    // Read path and interrupt lines
    always_comb begin
        stat_word = regs_q.status;
        bus_rdata = '0;
        if (rd_acc) begin
            if (hit_status)     bus_rdata = 32'(stat_word);
            else if (hit_div)   bus_rdata = regs_q.divtrim;
            else if (hit_tod)   bus_rdata = 32'(cal_now.tod);
            else if (hit_date)  bus_rdata = 32'(cal_now.date);
            else if (hit_atod)  bus_rdata = 32'(regs_q.alm_tod);
            else if (hit_adate) bus_rdata = 32'(regs_q.alm_date);
        end
        irq_alarm = (stat_word[ST_ALM_F] && stat_word[ST_ALM_EN])
                 || (stat_word[ST_CAL_F] && stat_word[ST_CAL_EN]);
        irq_tick  = stat_word[ST_TICK_F] && stat_word[ST_TICK_EN];
    end
endmodule

// File: rtl/rtc_checker.sv
`timescale 1ns/1ps
module rtc_checker #(
    parameter int unsigned DIV_W = 16
) (
    input logic             clk,
    input logic             rst_n,
    input logic             div_tick,
    input logic             wr_cal,
    input logic [DIV_W-1:0] div_val,
    input logic             alarm_hit,
    input logic [5:0]       stat_word,
    input logic [5:0]       sec_now,
    input logic             bus_en,
    input logic             bus_we,
    input logic             addr_hit,
    input logic [31:0]      bus_rdata,
    input logic             wr_status,
    input logic             irq_tick
);
    // R7
    tick_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        div_tick |=> stat_word[1]);

    // R6
    alarm_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
        alarm_hit |=> (stat_word[0] && stat_word[4]));

    // R5
    restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_cal && div_val != '0) |=> !div_tick);

    // R10
    unmapped_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_en && !bus_we && !addr_hit) |-> bus_rdata == '0);

    // R9
    tick_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && stat_word[3] && !wr_status) |=> irq_tick);

    // R3
    sec_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (div_tick && sec_now == 6'd30) |=> sec_now == 6'd31);
endmodule

bind cal_rtc rtc_checker #(.DIV_W(DIV_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .div_tick  (div_tick),
    .wr_cal    (wr_cal),
    .div_val   (regs_q.divtrim[DIV_W-1:0]),
    .alarm_hit (alarm_hit),
    .stat_word (stat_word),
    .sec_now   (cal_now.tod.second),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .addr_hit  (addr_hit),
    .bus_rdata (bus_rdata),
    .wr_status (wr_status),
    .irq_tick  (irq_tick)
);

// File: tb/tb_cal_rtc.sv
`timescale 1ns/1ps
module tb_cal_rtc;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ref_pulse = 1'b0;
    logic        bus_en = 1'b0;
    logic        bus_we = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_alarm, irq_tick;

    int checks = 0;
    int errors = 0;

    cal_rtc dut (
        .clk(clk), .rst_n(rst_n), .ref_pulse(ref_pulse),
        .bus_en(bus_en), .bus_we(bus_we), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .irq_alarm(irq_alarm), .irq_tick(irq_tick)
    );

    always #10 clk = ~clk;

    typedef struct packed {
        int y; int mo; int d; int h; int mi; int s;
        int ey; int emo; int ed; int eh; int emi; int es;
    } vec_t;

    localparam int NV = 12;
    localparam vec_t VEC [NV] = '{
        '{2023, 5,10,12,34,56, 2023, 5,10,12,34,57},
        '{2023, 5,10,12,34,59, 2023, 5,10,12,35, 0},
        '{2023, 5,10,12,59,59, 2023, 5,10,13, 0, 0},
        '{2023, 5,10,23,59,59, 2023, 5,11, 0, 0, 0},
        '{2023, 4,30,23,59,59, 2023, 5, 1, 0, 0, 0},
        '{2023,12,31,23,59,59, 2024, 1, 1, 0, 0, 0},
        '{2024, 2,28,23,59,59, 2024, 2,29, 0, 0, 0},
        '{2023, 2,28,23,59,59, 2023, 3, 1, 0, 0, 0},
        '{2100, 2,28,23,59,59, 2100, 3, 1, 0, 0, 0},
        '{2000, 2,28,23,59,59, 2000, 2,29, 0, 0, 0},
        '{2024, 2,29,23,59,59, 2024, 3, 1, 0, 0, 0},
        '{2023, 1,31,23,59,59, 2023, 2, 1, 0, 0, 0}
    };

    function automatic logic [31:0] pd(input int y, input int m, input int d);
        return 32'((y << 9) | (m << 5) | d);
    endfunction

    function automatic logic [31:0] pt(input int h, input int m, input int s);
        return 32'((h << 12) | (m << 6) | s);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=0x%08h expected=0x%08h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk); #1;
        bus_en = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        @(posedge clk); #1;
        bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        d = bus_rdata;
        bus_en = 1'b0;
    endtask

    task automatic pulse(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1; ref_pulse = 1'b1;
            @(posedge clk); #1; ref_pulse = 1'b0;
        end
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;

        // R1: reset state
        @(negedge clk);
        chk("R1 irq_alarm", 32'(irq_alarm), 32'd0);
        chk("R1 irq_tick", 32'(irq_tick), 32'd0);
        rd(8'h08, v); chk("R1 status", v, 32'h0);
        rd(8'h0C, v); chk("R1 divider", v, 32'h0);
        rd(8'h10, v); chk("R1 time", v, 32'h0);
        rd(8'h14, v); chk("R1 date", v, pd(2000, 1, 1));
        rd(8'h18, v); chk("R1 alarm time", v, 32'h0);
        rd(8'h1C, v); chk("R1 alarm date", v, 32'h0);

        // R3 R4: rollover table, divider 0 so each strobe ticks
        for (int i = 0; i < NV; i++) begin
            wr(8'h14, pd(VEC[i].y, VEC[i].mo, VEC[i].d));
            wr(8'h10, pt(VEC[i].h, VEC[i].mi, VEC[i].s));
            pulse(1);
            rd(8'h10, v); chk("R3 time step", v, pt(VEC[i].eh, VEC[i].emi, VEC[i].es));
            rd(8'h14, v); chk("R4 date step", v, pd(VEC[i].ey, VEC[i].emo, VEC[i].ed));
        end

        // R2: divider 3 with trim 5
        wr(8'h0C, 32'h0005_0003);
        rd(8'h0C, v); chk("R2 divider readback", v, 32'h0005_0003);
        wr(8'h10, pt(1, 0, 0));
        pulse(3);
        rd(8'h10, v); chk("R2 no tick before D+1", v, pt(1, 0, 0));
        pulse(1);
        rd(8'h10, v); chk("R2 tick on D+1", v, pt(1, 0, 1));

        // R5: write mid-count restarts the divider
        pulse(2);
        wr(8'h10, pt(2, 0, 0));
        rd(8'h10, v); chk("R5 write immediate", v, pt(2, 0, 0));
        pulse(3);
        rd(8'h10, v); chk("R5 count restarted", v, pt(2, 0, 0));
        pulse(1);
        rd(8'h10, v); chk("R5 tick after full period", v, pt(2, 0, 1));

        // R7 R8 R9: tick flag without and with enable
        wr(8'h0C, 32'h0);
        wr(8'h08, 32'h13);
        rd(8'h08, v); chk("R8 flags cleared", v, 32'h0);
        pulse(1);
        rd(8'h08, v); chk("R7 flag without enable", v, 32'h02);
        chk("R9 irq_tick masked", 32'(irq_tick), 32'd0);
        wr(8'h08, 32'h08);
        rd(8'h08, v); chk("R8 zero keeps flag", v, 32'h0A);
        chk("R9 irq_tick on", 32'(irq_tick), 32'd1);
        wr(8'h08, 32'h0A);
        rd(8'h08, v); chk("R8 w1c tick flag", v, 32'h08);
        chk("R9 irq_tick off", 32'(irq_tick), 32'd0);

        // R6: alarm
        wr(8'h1C, pd(2023, 5, 10));
        wr(8'h18, pt(12, 0, 5));
        rd(8'h1C, v); chk("R6 alarm date readback", v, pd(2023, 5, 10));
        rd(8'h18, v); chk("R6 alarm time readback", v, pt(12, 0, 5));
        wr(8'h08, 32'h26);
        wr(8'h14, pd(2023, 5, 10));
        wr(8'h10, pt(12, 0, 3));
        pulse(1);
        rd(8'h08, v); chk("R6 no match yet", v, 32'h26);
        chk("R9 irq_alarm low", 32'(irq_alarm), 32'd0);
        pulse(1);
        rd(8'h08, v); chk("R6 match sets flags", v, 32'h37);
        chk("R9 irq_alarm high", 32'(irq_alarm), 32'd1);
        wr(8'h08, 32'h25);
        rd(8'h08, v); chk("R8 clear bit0 only", v, 32'h36);
        chk("R9 irq_alarm via bit4", 32'(irq_alarm), 32'd1);
        wr(8'h08, 32'h34);
        rd(8'h08, v); chk("R8 clear bit4", v, 32'h26);
        chk("R9 irq_alarm cleared", 32'(irq_alarm), 32'd0);
        pulse(1);
        rd(8'h08, v); chk("R6 no refire off match", v, 32'h26);

        // R10: unmapped offsets and reserved bits
        rd(8'h04, v); chk("R10 offset 0x04", v, 32'h0);
        wr(8'h20, 32'hFFFF_FFFF);
        rd(8'h20, v); chk("R10 offset 0x20", v, 32'h0);
        rd(8'h09, v); chk("R10 unaligned", v, 32'h0);
        wr(8'h10, 32'hFFFF_FFFF);
        rd(8'h10, v); chk("R10 time reserved", v, 32'h0001_FFFF);
        wr(8'h14, 32'hFFFF_FFFF);
        rd(8'h14, v); chk("R10 date reserved", v, 32'h001F_FFFF);
        wr(8'h08, 32'hFFFF_FFFF);
        rd(8'h08, v); chk("R10 status reserved", v, 32'h2C);

        finish_run();
    end
endmodule